// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Target with Control-Byte Routing

This block is the two-wire serial target front end of a display driver. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. It shifts in the address byte and answers one of four addresses. The two low address bits come from strap inputs. A device whose address does not match gives no acknowledge and stays silent until the next START or STOP. Because several devices can share a strap setting and acknowledge together, the data line is only ever pulled low.

In a write transfer, the byte after the address is a control byte. Bit 6 of that byte selects where the following bytes go. A 1 routes them to a display RAM write port and a 0 routes them to a command port. Bit 7 is a continuation flag. When it is 0, every later byte in the transfer is data of the selected type. When it is 1, exactly one data byte follows and the next byte is again a control byte. In a read transfer, the block sends one status byte taken from a parallel input, MSB first. The controller then acknowledges and stops.

Top module: `i2c_rt_top`

## Requirements
- R1: Out of reset, `sda_pull` is 0 and neither `ram_wr_en` nor `cmd_valid` is asserted.
- R2: After a START, the first byte is the address, MSB first. It matches when bits 7..3 are 01110, bit 2 equals `strap[1]` and bit 1 equals `strap[0]`. Bit 0 is the read/write flag (1 = read). On a match the block pulls SDA low during the ninth clock.
- R3: On an address mismatch, the block gives no acknowledge and produces no write or command pulse for any byte until the next START or STOP.
- R4: In a write transfer, the byte after the address is a control byte and is acknowledged. Its bit 6 selects RAM (1) or command (0) for the following data, and its bits 5..0 have no effect.
- R5: With control bit 7 = 0, every following byte until START or STOP is data of the selected type.
- R6: With control bit 7 = 1, exactly one data byte follows, and the byte after it is treated as a new control byte.
- R7: Each accepted data byte is acknowledged and produces exactly one single-cycle pulse carrying the byte. The pulse is `ram_wr_en` with `ram_wdata` for RAM data, or `cmd_valid` with `cmd_data` for commands. The two pulses are never asserted together.
- R8: With read/write = 1, the block sends `status_byte` MSB first on SDA (a 0 bit is a pull). It releases SDA for the controller's acknowledge bit and does not drive any later byte.
- R9: A repeated START in the middle of a transfer makes the next byte an address again, whatever the routing state was.
- R10: After a STOP, SDA is released and bytes clocked without a new START get no acknowledge and produce no pulse.
- R11: `sda_pull` only changes while SCL is low, except when a START or STOP forces a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap | input | 2 | Address strap levels, bit 1 = address bit 2, bit 0 = address bit 1 |
| status_byte | input | 8 | Byte returned in a read transfer |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| ram_wr_en | output | 1 | One-cycle RAM data write strobe |
| ram_wdata | output | 8 | RAM data byte, valid with `ram_wr_en` |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_data | output | 8 | Command byte, valid with `cmd_valid` |

## Verification
The bench builds the block with its defaults: two synchroniser stages, address prefix 01110, continuation flag in bit 7 and select in bit 6. The bus is driven with a ten-cycle half period, so the three-cycle edge-detect latency always lands inside the low phase of SCL. With these values the bench exercises RAM runs, command runs, mixed routing with interleaved control bytes and both strap settings it uses. It also covers a mismatched address, a status read, a repeated START inside a data run and traffic sent with no START.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } rt_state_e;
endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rt_link.sv
module i2c_rt_link
  import i2c_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              ack_req,
  input  logic              tx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              start_ev,
  output logic              stop_ev,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              sda_pull
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic              scl_q, sda_q;
  logic              act_q, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              ackp_q, ackp_d;
  logic              txa_q, txa_d;
  logic              pull_q, pull_d;
  logic              rise, fall;

  assign rise      = scl_s & ~scl_q;
  assign fall      = ~scl_s & scl_q;
  assign start_ev  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev   = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_done = act_q & fall & (cnt_q == FULL) & ~ackp_q;
  assign byte_val  = sh_q;
  assign sda_pull  = pull_q;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ackp_d = ackp_q;
    txa_d  = txa_q;
    pull_d = pull_q;
    if (start_ev || stop_ev) begin
      act_d  = start_ev;
      cnt_d  = '0;
      ackp_d = 1'b0;
      txa_d  = 1'b0;
      pull_d = 1'b0;
    end else if (act_q) begin
      if (rise && !ackp_q && cnt_q != FULL) begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_d = cnt_q + 1'b1;
      end
      if (fall) begin
        if (ackp_q) begin
          ackp_d = 1'b0;
          cnt_d  = '0;
          txa_d  = tx_mode;
          tx_d   = tx_byte;
          pull_d = tx_mode & ~tx_byte[BYTE_W-1];
        end else if (cnt_q == FULL) begin
          ackp_d = 1'b1;
          txa_d  = 1'b0;
          pull_d = ack_req;
        end else if (txa_q && cnt_q != '0) begin
          tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
          pull_d = ~tx_q[BYTE_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ackp_q <= 1'b0;
      txa_q  <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ackp_q <= ackp_d;
      txa_q  <= txa_d;
      pull_q <= pull_d;
    end
  end

  // R11: drive changes only in the SCL low phase unless a bus condition released it
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pull_q) && !$past(start_ev || stop_ev)) |-> !$past(scl_s));

  // R10: STOP releases the line
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !pull_q);
endmodule

// File: rtl/i2c_rt_route.sv
module i2c_rt_route
  import i2c_rt_pkg::*;
#(
  parameter logic [BYTE_W-4:0] ADDR_HI  = 5'b01110,
  parameter int                CONT_BIT = 7,
  parameter int                SEL_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [1:0]        strap,
  output logic              ack_req,
  output logic              tx_mode,
  output logic              ram_wr_en,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data
);
  rt_state_e         st_q, st_d;
  logic              cont_q, cont_d, sel_q, sel_d;
  logic              ram_d, cmd_d;
  logic [BYTE_W-1:0] ramw_q, ramw_d, cmdw_q, cmdw_d;
  logic              ram_q, cmd_q;
  logic              addr_hit;

  assign addr_hit = (byte_val[BYTE_W-1:1] == {ADDR_HI, strap});
  assign ack_req  = byte_done && ((st_q == ST_ADDR && addr_hit) ||
                                  st_q == ST_CTRL || st_q == ST_DATA);
  assign tx_mode  = (st_q == ST_READ);

  always_comb begin
    st_d   = st_q;
    cont_d = cont_q;
    sel_d  = sel_q;
    ram_d  = 1'b0;
    cmd_d  = 1'b0;
    ramw_d = ramw_q;
    cmdw_d = cmdw_q;
    if (start_ev) begin
      st_d = ST_ADDR;
    end else if (stop_ev) begin
      st_d = ST_IDLE;
    end else if (byte_done) begin
      case (st_q)
        ST_ADDR: begin
          if (!addr_hit)       st_d = ST_SKIP;
          else if (byte_val[0]) st_d = ST_READ;
          else                 st_d = ST_CTRL;
        end
        ST_CTRL: begin
          cont_d = byte_val[CONT_BIT];
          sel_d  = byte_val[SEL_BIT];
          st_d   = ST_DATA;
        end
        ST_DATA: begin
          if (sel_q) begin
            ram_d  = 1'b1;
            ramw_d = byte_val;
          end else begin
            cmd_d  = 1'b1;
            cmdw_d = byte_val;
          end
          st_d = cont_q ? ST_CTRL : ST_DATA;
        end
        ST_READ: st_d = ST_SKIP;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cont_q <= 1'b0;
      sel_q  <= 1'b0;
      ram_q  <= 1'b0;
      cmd_q  <= 1'b0;
      ramw_q <= '0;
      cmdw_q <= '0;
    end else begin
      st_q   <= st_d;
      cont_q <= cont_d;
      sel_q  <= sel_d;
      ram_q  <= ram_d;
      cmd_q  <= cmd_d;
      ramw_q <= ramw_d;
      cmdw_q <= cmdw_d;
    end
  end

  assign ram_wr_en = ram_q;
  assign ram_wdata = ramw_q;
  assign cmd_valid = cmd_q;
  assign cmd_data  = cmdw_q;

  // R7: strobes are single-cycle and exclusive
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_q, cmd_q}));
  assert_ram_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_q |=> !ram_q);
  assert_cmd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q |=> !cmd_q);

  // R3: a byte seen while ignoring the transfer yields no strobe
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st_q == ST_SKIP) |=> (!ram_q && !cmd_q));
endmodule

// File: rtl/i2c_rt_top.sv
module i2c_rt_top
  import i2c_rt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-4:0] ADDR_HI     = 5'b01110,
  parameter int                CONT_BIT    = 7,
  parameter int                SEL_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_pull,
  output logic              ram_wr_en,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data
);
  logic              scl_s, sda_s;
  logic              start_ev, stop_ev, byte_done, ack_req, tx_mode;
  logic [BYTE_W-1:0] byte_val;

  i2c_rt_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));
  i2c_rt_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));

  i2c_rt_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ack_req(ack_req), .tx_mode(tx_mode), .tx_byte(status_byte),
    .start_ev(start_ev), .stop_ev(stop_ev), .byte_done(byte_done),
    .byte_val(byte_val), .sda_pull(sda_pull));

  i2c_rt_route #(.ADDR_HI(ADDR_HI), .CONT_BIT(CONT_BIT), .SEL_BIT(SEL_BIT)) u_route (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .byte_done(byte_done), .byte_val(byte_val), .strap(strap),
    .ack_req(ack_req), .tx_mode(tx_mode),
    .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data));
endmodule

// File: tb/i2c_rt_tb.sv
module i2c_rt_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [7:0] status_byte = 8'hC6;
  logic       sda_pull, ram_wr_en, cmd_valid;
  logic [7:0] ram_wdata, cmd_data;
  logic       sda_bus;

  int checks = 0;
  int failures = 0;
  int ram_n = 0;
  int cmd_n = 0;
  int bad_drive = 0;
  bit done = 0;
  logic [7:0] ram_log [0:15];
  logic [7:0] cmd_log [0:15];
  logic       pull_prev = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_rt_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap(strap),
    .status_byte(status_byte), .sda_pull(sda_pull), .ram_wr_en(ram_wr_en),
    .ram_wdata(ram_wdata), .cmd_valid(cmd_valid), .cmd_data(cmd_data));

  always @(negedge clk) begin
    if (ram_wr_en && ram_n < 16) begin ram_log[ram_n] = ram_wdata; ram_n++; end
    if (cmd_valid && cmd_n < 16) begin cmd_log[cmd_n] = cmd_data; cmd_n++; end
    if (ram_wr_en && cmd_valid) bad_drive++;
    if (sda_pull !== pull_prev && scl_m) bad_drive++;
    pull_prev = sda_pull;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(5); scl_m = 1'b1; wq(10);
    sda_m = 1'b0; wq(10); scl_m = 1'b0; wq(10);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq(5); sda_m = 1'b0; wq(5);
    scl_m = 1'b1; wq(10); sda_m = 1'b1; wq(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wq(5); sda_m = b[i]; wq(5);
      scl_m = 1'b1; wq(10);
    end
    scl_m = 1'b0; wq(5); sda_m = 1'b1; wq(5);
    scl_m = 1'b1; wq(5); acked = !sda_bus; wq(5);
    scl_m = 1'b0; wq(10);
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; sda_m = 1'b1; wq(10);
      scl_m = 1'b1; wq(5); b[i] = sda_bus; wq(5);
    end
    scl_m = 1'b0; wq(5); sda_m = 1'b0; wq(5);
    scl_m = 1'b1; wq(10);
    scl_m = 1'b0; wq(5); sda_m = 1'b1; wq(5);
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, tag, a, exp_ack);
  endtask

  task automatic clear_logs();
    ram_n = 0; cmd_n = 0;
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1 sda_pull after reset", sda_pull, 0);
    chk(!ram_wr_en && !cmd_valid, "R1 strobes after reset", {ram_wr_en, cmd_valid}, 0);
  endtask

  task automatic t_ram_run();
    clear_logs(); strap = 2'b10;
    bus_start();
    send_chk(8'h74, 1, "R2 address ack strap 10");
    send_chk(8'h40, 1, "R4 control ack");
    send_chk(8'hA5, 1, "R7 data ack");
    send_chk(8'h3C, 1, "R7 data ack");
    bus_stop();
    chk(ram_n == 2 && cmd_n == 0, "R5 ram run count", ram_n * 16 + cmd_n, 32);
    chk(ram_log[0] == 8'hA5 && ram_log[1] == 8'h3C, "R7 ram run data",
        {ram_log[0], ram_log[1]}, 16'hA53C);
  endtask

  task automatic t_mixed();
    clear_logs(); strap = 2'b10;
    bus_start();
    send_chk(8'h74, 1, "R2 address ack");
    send_chk(8'h80, 1, "R6 control cont cmd");
    send_chk(8'h12, 1, "R7 cmd ack");
    send_chk(8'h7F, 1, "R6 second control ack");
    send_chk(8'h99, 1, "R7 ram ack");
    send_chk(8'h66, 1, "R7 ram ack");
    bus_stop();
    chk(cmd_n == 1 && cmd_log[0] == 8'h12, "R6 single command", cmd_n, 1);
    chk(ram_n == 2 && ram_log[0] == 8'h99 && ram_log[1] == 8'h66,
        "R4 low bits ignored ram route", ram_n, 2);
  endtask

  task automatic t_cmd_run();
    clear_logs(); strap = 2'b10;
    bus_start();
    send_chk(8'h74, 1, "R2 address ack");
    send_chk(8'h3F, 1, "R4 command control with low bits set");
    send_chk(8'h01, 1, "R5 cmd ack");
    send_chk(8'h02, 1, "R5 cmd ack");
    send_chk(8'h03, 1, "R5 cmd ack");
    bus_stop();
    chk(cmd_n == 3 && ram_n == 0, "R5 command run count", cmd_n, 3);
    chk(cmd_log[0] == 8'h01 && cmd_log[1] == 8'h02 && cmd_log[2] == 8'h03,
        "R5 command run data", cmd_log[2], 3);
  endtask

  task automatic t_mismatch();
    clear_logs(); strap = 2'b10;
    bus_start();
    send_chk(8'h72, 0, "R3 wrong address no ack");
    send_chk(8'h40, 0, "R3 ignored control no ack");
    send_chk(8'hAA, 0, "R3 ignored data no ack");
    bus_stop();
    chk(ram_n == 0 && cmd_n == 0, "R3 no strobes", ram_n + cmd_n, 0);
  endtask

  task automatic t_other_strap();
    clear_logs(); strap = 2'b01;
    bus_start();
    send_chk(8'h72, 1, "R2 address ack strap 01");
    send_chk(8'h00, 1, "R4 command control");
    send_chk(8'h5A, 1, "R7 cmd ack");
    bus_stop();
    chk(cmd_n == 1 && cmd_log[0] == 8'h5A, "R2 strap 01 routing", cmd_n, 1);
    strap = 2'b10;
  endtask

  task automatic t_read();
    logic [7:0] rb;
    clear_logs(); strap = 2'b10; status_byte = 8'hC6;
    bus_start();
    send_chk(8'h75, 1, "R2 read address ack");
    read_byte(rb);
    chk(rb == 8'hC6, "R8 status byte", rb, 8'hC6);
    read_byte(rb);
    chk(rb == 8'hFF, "R8 no drive after status", rb, 8'hFF);
    bus_stop();
    status_byte = 8'h3B;
    bus_start();
    send_chk(8'h75, 1, "R2 read address ack");
    read_byte(rb);
    bus_stop();
    chk(rb == 8'h3B, "R8 second status byte", rb, 8'h3B);
    chk(ram_n == 0 && cmd_n == 0, "R8 read makes no strobes", ram_n + cmd_n, 0);
  endtask

  task automatic t_restart();
    clear_logs(); strap = 2'b10;
    bus_start();
    send_chk(8'h74, 1, "R2 address ack");
    send_chk(8'h40, 1, "R4 control ack");
    send_chk(8'h11, 1, "R7 ram ack");
    bus_start();
    send_chk(8'h74, 1, "R9 address after repeated start");
    send_chk(8'h00, 1, "R9 control after repeated start");
    send_chk(8'h22, 1, "R9 cmd ack");
    bus_stop();
    chk(ram_n == 1 && ram_log[0] == 8'h11, "R9 ram before restart", ram_n, 1);
    chk(cmd_n == 1 && cmd_log[0] == 8'h22, "R9 routing after restart", cmd_n, 1);
  endtask

  task automatic t_no_start();
    clear_logs(); strap = 2'b10;
    send_chk(8'h74, 0, "R10 no ack without start");
    send_chk(8'h40, 0, "R10 no ack without start");
    send_chk(8'h55, 0, "R10 no ack without start");
    chk(ram_n == 0 && cmd_n == 0, "R10 no strobes without start", ram_n + cmd_n, 0);
    chk(sda_pull == 1'b0, "R10 line released", sda_pull, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wq(5);
    t_reset();
    rst_n = 1'b1;
    wq(10);
    t_reset();
    t_ram_run();
    t_mixed();
    t_cmd_run();
    t_mismatch();
    t_other_strap();
    t_read();
    t_restart();
    t_no_start();
    chk(bad_drive == 0, "R11 drive changed with SCL high or strobes overlapped",
        bad_drive, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule